// File: doc/BRIEF.md
# Power-Up Strap Sampling Controller

This block governs a small group of dual-purpose pins. At power-up the pins act as configuration inputs, and afterwards they act as clock outputs. When the power-good indication rises, the block holds every pin driver in high impedance for a fixed window of reference-oscillator cycles. During that window, board-level resistors pull each pin high or low. When the window closes, the block captures the synchronized pin levels into holding flops, raises a done flag, and enables all the pin drivers one cycle later.

The captured bits feed the rest of the chip in three ways:
- Four bits form a frequency-select code.
- A register-driven override can replace that code on the frequency-select output at any time.
- The fifth bit decides what a neighbouring pin does. A low level makes that pin the bus-stop input. A high level leaves it as a reference clock output.

The captured values are cleared only when power-good falls. No other event touches them.

Top module: `strap_sample_ctrl`

## Requirements
- R1: While `pwr_good` is low, `sample_done`, `strap_oe`, `fs_code`, `mode_bit` and `stop_in_sel` are all zero, and `freq_sel` shows zero unless the override is selected.
- R2: `sample_done` rises on exactly the WINDOW_CYCLES-th rising edge of `clk_ref` after `pwr_good` goes high.
- R3: Throughout the window, up to and including the edge before `sample_done` rises, every bit of `strap_oe` is 0.
- R4: At the end of the window, `strap_pin_in[3:0]` is captured into `fs_code[3:0]` bit for bit, and `strap_pin_in[4]` is captured into `mode_bit`. Each pin passes through a two-flop synchronizer first, so the level must be steady for at least three edges before the window closes.
- R5: All bits of `strap_oe` go to 1 on the edge after `sample_done` rises. From then on, `sample_done` and `strap_oe` stay asserted while power is good.
- R6: Once `sample_done` is high, changes on `strap_pin_in` have no effect on `fs_code` or `mode_bit`.
- R7: A low pulse on `pwr_good` clears the captured values. The next rise of `pwr_good` starts a new window and a new capture.
- R8: `freq_sel` equals `reg_sel_code` whenever `use_reg_sel` is 1, and equals `fs_code` otherwise. This holds combinationally at any time, including during the window.
- R9: `stop_in_sel` is 1 only when `sample_done` is high and `mode_bit` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference oscillator clock |
| pwr_good | input | 1 | Supply above threshold. A low level acts as the power-off reset |
| strap_pin_in | input | FS_W+1 | Pin levels as seen at the pads: bits [3:0] are the frequency straps, bit 4 is the mode strap |
| use_reg_sel | input | 1 | Selects the register code instead of the strapped code |
| reg_sel_code | input | FS_W | Frequency code from the configuration register |
| strap_oe | output | FS_W+1 | Output-driver enables for the shared pins |
| sample_done | output | 1 | Capture complete |
| fs_code | output | FS_W | Captured frequency straps |
| mode_bit | output | 1 | Captured mode strap |
| freq_sel | output | FS_W | Effective frequency code |
| stop_in_sel | output | 1 | Neighbouring pin acts as the bus-stop input |

## Verification
The timing of each result, counted from the release of `pwr_good`, is as follows:
- `sample_done` and the captured straps appear after edge WINDOW_CYCLES.
- The driver enables appear after edge WINDOW_CYCLES+1.
- `freq_sel` and `stop_in_sel` follow their inputs without a register stage.
- A fall of `pwr_good` clears state asynchronously, within the same cycle.

The bench queues every expected output word tagged with the edge index at which it becomes due. It compares the queued word at the falling edge of that cycle. For the strap test, the pins first hold misleading values and then settle ten edges before the window closes, which exercises the synchronizer latency.

// File: rtl/strap_pkg.sv
package strap_pkg;
    typedef enum logic [1:0] {
        PH_SAMPLE = 2'd0,
        PH_ENABLE = 2'd1,
        PH_RUN    = 2'd2
    } phase_e;
endpackage

// File: rtl/strap_sync.sv
module strap_sync #(
    parameter int WIDTH = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    typedef struct packed {
        logic [WIDTH-1:0] meta;
        logic [WIDTH-1:0] stable;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        s_d.meta   = din;
        s_d.stable = s_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign dout = s_q.stable;
endmodule

// File: rtl/strap_timer.sv
module strap_timer #(
    parameter int COUNT = 28637
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic expire
);
    localparam int CW = $clog2(COUNT + 1);
    localparam logic [CW-1:0] LAST = CW'(COUNT - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (en && cnt_q != LAST) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expire = en && (cnt_q == LAST);
endmodule

// File: rtl/strap_sample_ctrl.sv
module strap_sample_ctrl
    import strap_pkg::*;
#(
    parameter int WINDOW_CYCLES = 28637,
    parameter int FS_W          = 4
) (
    input  logic            clk_ref,
    input  logic            pwr_good,
    input  logic [FS_W:0]   strap_pin_in,
    input  logic            use_reg_sel,
    input  logic [FS_W-1:0] reg_sel_code,
    output logic [FS_W:0]   strap_oe,
    output logic            sample_done,
    output logic [FS_W-1:0] fs_code,
    output logic            mode_bit,
    output logic [FS_W-1:0] freq_sel,
    output logic            stop_in_sel
);
    localparam int NPINS = FS_W + 1;

    typedef struct packed {
        phase_e           phase;
        logic [NPINS-1:0] straps;
        logic             done;
        logic             oe;
    } ctrl_t;

    ctrl_t            st_d, st_q;
    logic [NPINS-1:0] pins_sync;
    logic             win_end;

    strap_sync #(.WIDTH(NPINS)) u_sync (
        .clk   (clk_ref),
        .rst_n (pwr_good),
        .din   (strap_pin_in),
        .dout  (pins_sync)
    );

    strap_timer #(.COUNT(WINDOW_CYCLES)) u_timer (
        .clk    (clk_ref),
        .rst_n  (pwr_good),
        .en     (st_q.phase == PH_SAMPLE),
        .expire (win_end)
    );

    always_comb begin
        st_d = st_q;
        unique case (st_q.phase)
            PH_SAMPLE: begin
                if (win_end) begin
                    st_d.straps = pins_sync;
                    st_d.done   = 1'b1;
                    st_d.phase  = PH_ENABLE;
                end
            end
            PH_ENABLE: begin
                st_d.oe    = 1'b1;
                st_d.phase = PH_RUN;
            end
            default: st_d.phase = PH_RUN;
        endcase
    end

    always_ff @(posedge clk_ref or negedge pwr_good) begin
        if (!pwr_good) st_q <= '{phase: PH_SAMPLE, straps: '0, done: 1'b0, oe: 1'b0};
        else           st_q <= st_d;
    end

    assign strap_oe    = {NPINS{st_q.oe}};
    assign sample_done = st_q.done;
    assign fs_code     = st_q.straps[FS_W-1:0];
    assign mode_bit    = st_q.straps[FS_W];
    assign freq_sel    = use_reg_sel ? reg_sel_code : st_q.straps[FS_W-1:0];
    assign stop_in_sel = st_q.done & ~st_q.straps[FS_W];
endmodule

// File: rtl/strap_sample_chk.sv
module strap_sample_chk #(
    parameter int WINDOW_CYCLES = 28637,
    parameter int FS_W          = 4
) (
    input logic            clk_ref,
    input logic            pwr_good,
    input logic [FS_W:0]   strap_oe,
    input logic            sample_done,
    input logic [FS_W-1:0] fs_code,
    input logic            mode_bit
);
    localparam int CW = $clog2(WINDOW_CYCLES + 2);
    localparam logic [CW-1:0] SAT = CW'(WINDOW_CYCLES + 1);

    logic [CW-1:0] edges_q;

    always_ff @(posedge clk_ref or negedge pwr_good) begin
        if (!pwr_good)        edges_q <= '0;
        else if (edges_q != SAT) edges_q <= edges_q + 1'b1;
    end

    assert_window_len_R2: assert property (@(posedge clk_ref) disable iff (!pwr_good)
        $rose(sample_done) |-> (edges_q == CW'(WINDOW_CYCLES)));

    assert_oe_needs_done_R3: assert property (@(posedge clk_ref) disable iff (!pwr_good)
        (strap_oe != '0) |-> sample_done);

    assert_oe_follows_done_R5: assert property (@(posedge clk_ref) disable iff (!pwr_good)
        $rose(sample_done) |-> (strap_oe == '0) ##1 (strap_oe == '1));

    assert_done_sticky_R5: assert property (@(posedge clk_ref) disable iff (!pwr_good)
        sample_done |=> sample_done);

    assert_oe_uniform_R5: assert property (@(posedge clk_ref) disable iff (!pwr_good)
        (strap_oe == '0) || (strap_oe == '1));

    assert_straps_hold_R6: assert property (@(posedge clk_ref) disable iff (!pwr_good)
        sample_done |=> ($stable(fs_code) && $stable(mode_bit)));
endmodule

bind strap_sample_ctrl strap_sample_chk #(
    .WINDOW_CYCLES (WINDOW_CYCLES),
    .FS_W          (FS_W)
) u_chk (
    .clk_ref     (clk_ref),
    .pwr_good    (pwr_good),
    .strap_oe    (strap_oe),
    .sample_done (sample_done),
    .fs_code     (fs_code),
    .mode_bit    (mode_bit)
);

// File: tb/tb_strap_sample_ctrl.sv
module tb_strap_sample_ctrl;
    localparam int W = 48;

    typedef struct {
        int          at;
        string       req;
        logic [15:0] exp;
    } exp_t;

    logic       clk_ref = 1'b0;
    logic       pwr_good = 1'b0;
    logic [4:0] pins = '0;
    logic       use_reg = 1'b0;
    logic [3:0] reg_code = '0;
    logic [4:0] strap_oe;
    logic       sample_done, mode_bit, stop_in_sel;
    logic [3:0] fs_code, freq_sel;

    int   cyc = 0;
    int   n_run = 0;
    int   n_fail = 0;
    exp_t sb[$];
    exp_t mon_item;

    strap_sample_ctrl #(.WINDOW_CYCLES(W), .FS_W(4)) dut (
        .clk_ref      (clk_ref),
        .pwr_good     (pwr_good),
        .strap_pin_in (pins),
        .use_reg_sel  (use_reg),
        .reg_sel_code (reg_code),
        .strap_oe     (strap_oe),
        .sample_done  (sample_done),
        .fs_code      (fs_code),
        .mode_bit     (mode_bit),
        .freq_sel     (freq_sel),
        .stop_in_sel  (stop_in_sel)
    );

    always #10 clk_ref = ~clk_ref;
    always @(posedge clk_ref) cyc <= cyc + 1;

    function automatic logic [15:0] mk(logic done, logic oe, logic [3:0] fs,
                                       logic md, logic [3:0] fq, logic stp);
        return {done, {5{oe}}, fs, md, fq, stp};
    endfunction

    task automatic push(int at, string req, logic [15:0] e);
        exp_t it;
        it.at = at; it.req = req; it.exp = e;
        sb.push_back(it);
    endtask

    always @(negedge clk_ref) begin
        while (sb.size() > 0 && sb[0].at <= cyc) begin
            mon_item = sb.pop_front();
            n_run++;
            if (mon_item.at != cyc) begin
                n_fail++;
                $display("FAIL %s: check missed, due cycle %0d actual cycle %0d",
                         mon_item.req, mon_item.at, cyc);
            end else if ({sample_done, strap_oe, fs_code, mode_bit, freq_sel, stop_in_sel}
                         !== mon_item.exp) begin
                n_fail++;
                $display("FAIL %s: cycle %0d actual %h expected %h", mon_item.req, cyc,
                         {sample_done, strap_oe, fs_code, mode_bit, freq_sel, stop_in_sel},
                         mon_item.exp);
            end
        end
    end

    task automatic power_up(input logic [4:0] early, input logic [4:0] fin,
                            input logic ureg, input logic [3:0] rcode);
        int          base;
        logic [3:0]  fq_pre, fq_post;
        logic [15:0] done_word;
        @(posedge clk_ref); #1;
        pins = early; use_reg = ureg; reg_code = rcode; pwr_good = 1'b1;
        base    = cyc;
        fq_pre  = ureg ? rcode : 4'h0;
        fq_post = ureg ? rcode : fin[3:0];
        push(base + 2, "R3 window start", mk(0, 0, 4'h0, 0, fq_pre, 0));
        repeat (W - 10) @(posedge clk_ref);
        #1 pins = fin;
        push(base + W - 1, "R3 last window edge", mk(0, 0, 4'h0, 0, fq_pre, 0));
        done_word = mk(1, 0, fin[3:0], fin[4], fq_post, ~fin[4]);
        push(base + W, "R2 R4 R9 capture", done_word);
        push(base + W + 1, "R5 drivers on", mk(1, 1, fin[3:0], fin[4], fq_post, ~fin[4]));
        repeat (12) @(posedge clk_ref);
        #1 pins = ~fin;
        push(base + W + 5, "R6 pins ignored", mk(1, 1, fin[3:0], fin[4], fq_post, ~fin[4]));
        repeat (6) @(posedge clk_ref);
    endtask

    task automatic power_down();
        @(posedge clk_ref); #1;
        pwr_good = 1'b0;
        push(cyc, "R7 R1 cleared", mk(0, 0, 4'h0, 0, use_reg ? reg_code : 4'h0, 0));
        repeat (3) @(posedge clk_ref);
    endtask

    task automatic report();
        if (sb.size() != 0) begin
            n_fail++;
            $display("FAIL R2: %0d checks never reached, actual 0 expected %0d",
                     sb.size(), sb.size());
        end
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk_ref);
        n_fail++;
        $display("FAIL watchdog: actual cycle %0d expected end before it", cyc);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (2) @(posedge clk_ref);
        #1 push(cyc, "R1 reset state", mk(0, 0, 4'h0, 0, 4'h0, 0));
        repeat (2) @(posedge clk_ref);

        // mode 0, fs 1011, strapped path
        power_up(5'b11111, 5'b0_1011, 1'b0, 4'h0);
        @(posedge clk_ref); #1;
        use_reg = 1'b1; reg_code = 4'hC;
        push(cyc, "R8 override", mk(1, 1, 4'hB, 0, 4'hC, 1));
        @(posedge clk_ref); #1;
        use_reg = 1'b0;
        push(cyc, "R8 back to straps", mk(1, 1, 4'hB, 0, 4'hB, 1));
        power_down();

        // mode 1, fs 0110: neighbour pin stays a clock output
        power_up(5'b00000, 5'b1_0110, 1'b0, 4'h0);
        power_down();

        // override active during the window
        power_up(5'b10101, 5'b0_0001, 1'b1, 4'h9);
        repeat (4) @(posedge clk_ref);
        report();
    end
endmodule